// File: doc/BRIEF.md
# Supply Supervisor Reset and Interrupt Controller

This block is the digital side of a supply supervisor. Three analog comparators report, as plain digital levels, whether the supply sits below the power-on level, below the low-voltage detect level, and below either of two warning levels. The block synchronizes those levels and drives a system reset hold. The hold begins on a power-on event, and also on a detected low voltage if software has armed that response. It stays asserted until the supply has recovered.

The low-voltage detector can instead act as an interrupt source. In that mode a detection sets a sticky flag, which software acknowledges, and the interrupt request is that flag gated by an enable. A separate warning bit gives a live, interrupt-free view of the selected warning comparator. A cause register records whether the most recent reset came from power-on or from low voltage. All of this is reached through a small synchronous read/write register port. The control register sits at address 0 and the cause register at address 1.

Top module: `lvr_ctrl`

## Requirements
- R1: A high on `por_cmp_i`, or `rst`, holds `sys_rst_o` at 1. The hold is released only once both `por_cmp_i` and `lvd_cmp_i` read low. Every comparator passes two synchronizer flops before use, so `sys_rst_o` responds on the third rising edge after a comparator change.
- R2: After a power-on event, the cause register (address 1) reads bit 0 (power-on cause) = 1 and bit 1 (low-voltage cause) = 1.
- R3: With control bit 0 (detect enable) = 1 and bit 2 (reset response) = 1, a high `lvd_cmp_i` in normal operation asserts `sys_rst_o`. The reset is then held until `lvd_cmp_i` reads low again.
- R4: A low-voltage reset sets the cause register to bit 1 = 1 and bit 0 = 0.
- R5: The cause register changes only when a reset begins. Writes to address 1 leave it unchanged.
- R6: With detect enable = 1 and reset response = 0, a high `lvd_cmp_i` sets a sticky flag (control bit 6) without asserting reset. The flag stays set after the comparator returns low.
- R7: `irq_o` equals the flag ANDed with control bit 1 (interrupt enable). It updates on the same edge as the flag or the enable.
- R8: Writing 1 to control bit 4 (acknowledge) clears the flag. If a detection is present on the same edge, the detection wins. Bit 4 always reads 0.
- R9: With detect enable = 0, `lvd_cmp_i` neither sets the flag nor asserts reset.
- R10: Control bit 7 reads the synchronized warning comparator, live. Bit 3 = 1 selects `warn_hi_cmp_i` and bit 3 = 0 selects `warn_lo_cmp_i`. The warning never drives `irq_o`.
- R11: Control bits 3..0 reset to 0x5 (detect and reset response on) on power-on and on `rst`. They keep their written values through a low-voltage reset.
- R12: Read data appears one cycle after the read. Addresses other than 0 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, treated as power-on |
| por_cmp_i | input | 1 | Supply below power-on level (asynchronous) |
| lvd_cmp_i | input | 1 | Supply below low-voltage detect level (asynchronous) |
| warn_hi_cmp_i | input | 1 | Supply below high warning level (asynchronous) |
| warn_lo_cmp_i | input | 1 | Supply below low warning level (asynchronous) |
| bus_en_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| sys_rst_o | output | 1 | System reset hold |
| irq_o | output | 1 | Low-voltage interrupt request |

## Verification
The bench builds the block with SYNC_STAGES = 2 and DATA_W = 8, which makes the three-edge comparator latency exact and checkable. It also widens ADDR_W to 2, which exposes two unmapped addresses so the read-as-zero decode can be tested. The default control value 0x5 is kept, so power-on can be seen restoring it after other values have been written.

// File: rtl/lvr_pkg.sv
package lvr_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_HOLD_POR = 2'd1,
    ST_HOLD_LVD = 2'd2
  } lvr_state_e;

  // control register bit positions
  localparam int unsigned CB_DET  = 0;
  localparam int unsigned CB_IEN  = 1;
  localparam int unsigned CB_REN  = 2;
  localparam int unsigned CB_WSEL = 3;
  localparam int unsigned CB_ACK  = 4;
  localparam int unsigned CB_FLAG = 6;
  localparam int unsigned CB_WARN = 7;
  localparam int unsigned CTRL_W  = 4;

  // register addresses
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_CAUSE = 1;

  // cause encodings: bit0 power-on, bit1 low voltage
  localparam logic [1:0] CAUSE_POR = 2'b11;
  localparam logic [1:0] CAUSE_LVD = 2'b10;

endpackage

// File: rtl/lvr_sync.sv
module lvr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) stage_q <= '0;
      else     stage_q[0] <= async_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage_q <= '0;
      else     stage_q <= {stage_q[STAGES-2:0], async_i};
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/lvr_seq.sv
module lvr_seq
  import lvr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       por_s,
  input  logic       lvd_s,
  input  logic       det_en,
  input  logic       rst_en,
  output logic       sys_rst_o,
  output logic [1:0] cause_o
);

  lvr_state_e state_q, state_d;
  logic       rst_q, rst_d;
  logic [1:0] cause_q, cause_d;
  logic       lvd_arm;

  assign lvd_arm = lvd_s && det_en && rst_en;

  always_comb begin
    state_d = state_q;
    rst_d   = rst_q;
    cause_d = cause_q;
    case (state_q)
      ST_RUN: begin
        if (por_s) begin
          state_d = ST_HOLD_POR;
          rst_d   = 1'b1;
          cause_d = CAUSE_POR;
        end else if (lvd_arm) begin
          state_d = ST_HOLD_LVD;
          rst_d   = 1'b1;
          cause_d = CAUSE_LVD;
        end
      end
      default: begin
        if (por_s) begin
          state_d = ST_HOLD_POR;
          cause_d = CAUSE_POR;
        end else if (!lvd_s) begin
          state_d = ST_RUN;
          rst_d   = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HOLD_POR;
      rst_q   <= 1'b1;
      cause_q <= CAUSE_POR;
    end else begin
      state_q <= state_d;
      rst_q   <= rst_d;
      cause_q <= cause_d;
    end
  end

  assign sys_rst_o = rst_q;
  assign cause_o   = cause_q;

  assert_por_holds_R1: assert property (@(posedge clk) disable iff (rst)
    por_s |=> rst_q);

  assert_release_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_q) |-> ($past(!lvd_s) && $past(!por_s)));

  assert_por_cause_R2: assert property (@(posedge clk) disable iff (rst)
    por_s |=> (cause_q == CAUSE_POR));

  assert_lvd_reset_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !por_s && lvd_arm) |=> rst_q);

  assert_lvd_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !por_s && lvd_arm) |=> (cause_q == CAUSE_LVD));

  assert_cause_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !rst_q |-> $stable(cause_q));

endmodule

// File: rtl/lvr_regs.sv
module lvr_regs
  import lvr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 1,
  parameter logic [3:0]  CTRL_DEFAULT = 4'h5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              por_s,
  input  logic              lvd_s,
  input  logic              warn_hi_s,
  input  logic              warn_lo_s,
  input  logic [1:0]        cause_i,
  output logic              det_en_o,
  output logic              rst_en_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(ADDR_CAUSE);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              flag_q, flag_d;
  logic              irq_q, irq_d;
  logic [DATA_W-1:0] rdata_q, rd_d;
  logic              ctrl_wr, ack_wr, set_evt, warn_live;

  assign ctrl_wr   = bus_en && bus_wr && (bus_addr == A_CTRL);
  assign ack_wr    = ctrl_wr && bus_wdata[CB_ACK];
  assign set_evt   = lvd_s && ctrl_q[CB_DET] && !ctrl_q[CB_REN];
  assign warn_live = ctrl_q[CB_WSEL] ? warn_hi_s : warn_lo_s;

  always_comb begin
    ctrl_d = ctrl_q;
    flag_d = flag_q;
    if (por_s) begin
      ctrl_d = CTRL_DEFAULT;
      flag_d = 1'b0;
    end else begin
      if (ctrl_wr) ctrl_d = bus_wdata[CTRL_W-1:0];
      if (ack_wr)  flag_d = 1'b0;
      if (set_evt) flag_d = 1'b1;
    end
    irq_d = flag_d && ctrl_d[CB_IEN];
  end

  always_comb begin
    rd_d = '0;
    if (bus_addr == A_CTRL) begin
      rd_d[CTRL_W-1:0] = ctrl_q;
      rd_d[CB_FLAG]    = flag_q;
      rd_d[CB_WARN]    = warn_live;
    end else if (bus_addr == A_CAUSE) begin
      rd_d[1:0] = cause_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_DEFAULT;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
      if (bus_en && !bus_wr) rdata_q <= rd_d;
    end
  end

  assign det_en_o = ctrl_q[CB_DET];
  assign rst_en_o = ctrl_q[CB_REN];
  assign irq_o    = irq_q;
  assign rdata_o  = rdata_q;

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
    (set_evt && !por_s) |=> flag_q);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !por_s && !ack_wr) |=> flag_q);

  assert_irq_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && ctrl_q[CB_IEN] && !por_s && !ack_wr && !ctrl_wr) |=> irq_q);

  assert_ack_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && !set_evt && !por_s) |=> !flag_q);

  assert_det_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !ctrl_q[CB_DET]) |=> !flag_q);

endmodule

// File: rtl/lvr_ctrl.sv
module lvr_ctrl
  import lvr_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ADDR_W       = 1,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter logic [3:0]  CTRL_DEFAULT = 4'h5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_cmp_i,
  input  logic              lvd_cmp_i,
  input  logic              warn_hi_cmp_i,
  input  logic              warn_lo_cmp_i,
  input  logic              bus_en_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              sys_rst_o,
  output logic              irq_o
);

  localparam int unsigned N_CMP = 4;

  logic [N_CMP-1:0] cmp_raw, cmp_s;
  logic             det_en, rst_en;
  logic [1:0]       cause;

  assign cmp_raw = {warn_lo_cmp_i, warn_hi_cmp_i, lvd_cmp_i, por_cmp_i};

  lvr_sync #(
    .WIDTH  (N_CMP),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (cmp_raw),
    .sync_o  (cmp_s)
  );

  lvr_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .por_s     (cmp_s[0]),
    .lvd_s     (cmp_s[1]),
    .det_en    (det_en),
    .rst_en    (rst_en),
    .sys_rst_o (sys_rst_o),
    .cause_o   (cause)
  );

  lvr_regs #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .CTRL_DEFAULT (CTRL_DEFAULT)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en_i),
    .bus_wr    (bus_wr_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .por_s     (cmp_s[0]),
    .lvd_s     (cmp_s[1]),
    .warn_hi_s (cmp_s[2]),
    .warn_lo_s (cmp_s[3]),
    .cause_i   (cause),
    .det_en_o  (det_en),
    .rst_en_o  (rst_en),
    .irq_o     (irq_o),
    .rdata_o   (bus_rdata_o)
  );

endmodule

// File: tb/lvr_ctrl_test.sv
module lvr_ctrl_test;

  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          por = 1'b0, lvd = 1'b0, whi = 1'b0, wlo = 1'b0;
  logic          en = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          sys_rst, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  lvr_ctrl #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2), .CTRL_DEFAULT(4'h5)) uut (
    .clk(clk), .rst(rst),
    .por_cmp_i(por), .lvd_cmp_i(lvd), .warn_hi_cmp_i(whi), .warn_lo_cmp_i(wlo),
    .bus_en_i(en), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .sys_rst_o(sys_rst), .irq_o(irq)
  );

  function automatic logic [7:0] exp_ctrl(input logic [3:0] c, input logic f, input logic w);
    return {w, f, 2'b00, c};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    en = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    en = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    en = 1'b1; wr = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk);
    en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] d;
    int seed;
    seed = $urandom(32'd20240607);

    // reset state
    tick(3);
    check("R1 held during rst", sys_rst, 1);
    rst = 1'b0;
    tick(1);
    check("R1 release after rst", sys_rst, 0);
    rd_reg(1, d); check("R2 cause after rst", d, 8'h03);
    rd_reg(0, d); check("R11 control default", d, 8'h05);

    // power-on event, held until low-voltage clears
    por = 1'b1; lvd = 1'b1;
    tick(2); check("R1 sync latency", sys_rst, 0);
    tick(1); check("R1 por asserts reset", sys_rst, 1);
    por = 1'b0;
    tick(5); check("R1 held while lvd high", sys_rst, 1);
    lvd = 1'b0;
    tick(2); check("R1 still held before sync", sys_rst, 1);
    tick(1); check("R1 released", sys_rst, 0);
    rd_reg(1, d); check("R2 cause after power-on", d, 8'h03);

    // low-voltage reset
    wr_reg(0, 8'h0D);
    lvd = 1'b1;
    tick(3); check("R3 lvd asserts reset", sys_rst, 1);
    rd_reg(1, d); check("R4 lvd cause", d, 8'h02);
    rd_reg(0, d); check("R11 control kept over lvd reset", d, 8'h0D);
    tick(4); check("R3 held while lvd high", sys_rst, 1);
    lvd = 1'b0;
    tick(3); check("R3 released", sys_rst, 0);
    wr_reg(1, 8'hFF);
    rd_reg(1, d); check("R5 cause write ignored", d, 8'h02);

    // interrupt mode
    wr_reg(0, 8'h03);
    lvd = 1'b1;
    tick(3);
    check("R6 no reset in interrupt mode", sys_rst, 0);
    check("R7 irq raised", irq, 1);
    rd_reg(0, d); check("R6 flag set", d, 8'h43);
    lvd = 1'b0;
    tick(3);
    rd_reg(0, d); check("R6 flag sticky", d, 8'h43);
    wr_reg(0, 8'h13);
    check("R8 ack drops irq", irq, 0);
    rd_reg(0, d); check("R8 ack clears flag, ack reads 0", d, 8'h03);
    lvd = 1'b1;
    tick(3);
    wr_reg(0, 8'h13);
    rd_reg(0, d); check("R8 detection wins over ack", d, 8'h43);
    check("R8 irq kept", irq, 1);
    lvd = 1'b0;
    tick(3);
    wr_reg(0, 8'h13);
    wr_reg(0, 8'h01);
    lvd = 1'b1;
    tick(3); check("R7 masked irq", irq, 0);
    lvd = 1'b0;
    tick(3);
    rd_reg(0, d); check("R7 flag set while masked", d, 8'h41);
    wr_reg(0, 8'h03); check("R7 unmask raises irq", irq, 1);
    wr_reg(0, 8'h13); check("R8 ack after unmask", irq, 0);

    // detection disabled
    wr_reg(0, 8'h04);
    lvd = 1'b1;
    tick(5); check("R9 no reset with detect off", sys_rst, 0);
    rd_reg(0, d); check("R9 no flag with detect off", d, 8'h04);
    wr_reg(0, 8'h02);
    tick(2);
    rd_reg(0, d); check("R9 no flag, interrupt mode", d, 8'h02);
    check("R9 no irq", irq, 0);
    lvd = 1'b0;
    tick(3);

    // warning flag
    wr_reg(0, 8'h05);
    wlo = 1'b1; whi = 1'b1;
    tick(3);
    rd_reg(0, d); check("R10 low trip warning", d, 8'h85);
    check("R10 warning no irq", irq, 0);
    whi = 1'b0;
    tick(3);
    wr_reg(0, 8'h0D);
    rd_reg(0, d); check("R10 high trip selected", d, 8'h0D);
    wr_reg(0, 8'h05);
    rd_reg(0, d); check("R10 low trip reselected", d, 8'h85);
    wlo = 1'b0;
    tick(3);

    // unmapped
    rd_reg(2, d); check("R12 unmapped address 2", d, 8'h00);
    rd_reg(3, d); check("R12 unmapped address 3", d, 8'h00);

    // power-on restores defaults
    wr_reg(0, 8'h0B);
    por = 1'b1;
    tick(3); check("R1 por reset", sys_rst, 1);
    por = 1'b0;
    tick(3); check("R1 por release", sys_rst, 0);
    rd_reg(0, d); check("R11 power-on restores default", d, 8'h05);
    rd_reg(1, d); check("R2 cause after second power-on", d, 8'h03);

    // random interrupt-mode and warning patterns
    for (int i = 0; i < 40; i++) begin
      logic [31:0] r;
      logic [3:0]  c;
      logic        pulse, fexp, wexp;
      r = $urandom;
      c = {r[3], 1'b0, r[1], r[0]};
      pulse = r[4];
      wr_reg(0, {4'h1, c});
      whi = r[5]; wlo = r[6];
      lvd = pulse;
      tick(3);
      lvd = 1'b0;
      tick(3);
      fexp = c[0] & pulse;
      wexp = c[3] ? r[5] : r[6];
      rd_reg(0, d); check("R6 random flag/warn", d, exp_ctrl(c, fexp, wexp));
      check("R7 random irq", irq, fexp & c[1]);
      check("R9 random no reset", sys_rst, 0);
    end

    done = 1;
    finish_run();
  end

endmodule